// File: doc/BRIEF.md
# Cascaded Ripple Magnitude Comparator

This block compares two unsigned words of a configurable width and reports whether the first is greater than, equal to, or less than the second. It is purely combinational. The decision is built by a chain of one-bit slices. Each slice sees one bit from each operand, plus a "greater so far" and a "less so far" flag from the slice below it.

The slice at bit 0 starts with both flags clear. Each slice lets a difference in its own bit override whatever came from below. When its two bits match, it forwards the incoming flags unchanged. The most significant slice therefore holds the verdict of the highest differing bit. Its three outputs are the block's results.

There is no state machine, clock or reset in the block. Its only modes are the three result codes. The bench uses a clock solely to pace stimulus and sampling.

Top module: `ripple_mag_cmp`

## Requirements
- R1: `a_gt_b` is 1 exactly when `a_val` is greater than `b_val`, with both read as unsigned numbers.
- R2: `a_lt_b` is 1 exactly when `a_val` is less than `b_val`, with both read as unsigned numbers.
- R3: `a_eq_b` is 1 exactly when the two operands are bit-for-bit identical. Inside the chain, the equal output of slice k is 1 exactly when bits k down to 0 of the two operands match.
- R4: For every input pair, exactly one of {`a_gt_b`, `a_eq_b`, `a_lt_b`} is 1.
- R5: The most significant differing bit alone decides the result. For example, with a width of 4, a=4'b1000 and b=4'b0111 give greater, even though every lower bit favours b.
- R6: When the upper bits match, the decision falls through to the lower bits. For example, with a width of 4, a=4'b0001 and b=4'b0000 give greater, and a=4'b1110 and b=4'b1111 give less.
- R7: The greater and less flags passed between slices are never both 1. The chain is seeded with both flags 0 below bit 0.
- R8: The operand width is set by the parameter `WIDTH` (default 4). The behaviour above holds at the default width and at a wider setting such as 12, including at all-zero and all-one operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_val | input | WIDTH | First unsigned operand |
| b_val | input | WIDTH | Second unsigned operand |
| a_gt_b | output | 1 | 1 when a_val > b_val |
| a_eq_b | output | 1 | 1 when a_val == b_val |
| a_lt_b | output | 1 | 1 when a_val < b_val |

## Verification
The two functions that can meet in one evaluation are a slice's own bit override and the propagation of the opposite flag from below. This happens when the lower bits favour one operand and a higher bit favours the other. The bench provokes it with patterns such as 1000 against 0111 and 0111 against 1000, at the 4-bit width and at the 12-bit width. It judges the outcome by requiring that only the flag chosen by the higher bit reaches the outputs, and that the three outputs stay one-hot.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    // Flags passed from one slice to the next more significant slice
    typedef struct packed {
        logic gt;
        logic lt;
    } rel_t;

    localparam rel_t REL_NONE = '{gt: 1'b0, lt: 1'b0};
endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
(
    input  logic x_bit,
    input  logic y_bit,
    input  rel_t carry_in,
    output rel_t carry_out,
    output logic eq_out
);
    // Every output is assigned on every path
    always_comb begin
        carry_out.gt = (x_bit & ~y_bit) | (x_bit & carry_in.gt) | (~y_bit & carry_in.gt);
        carry_out.lt = (~x_bit & y_bit) | (~x_bit & carry_in.lt) | (y_bit & carry_in.lt);
        eq_out       = ~(x_bit ^ y_bit) & ~carry_in.gt & ~carry_in.lt;
    end

    // Flags arriving from the neighbour below must not conflict
    always_comb begin
        assert_flags_exclusive_R7: assert (!(carry_in.gt && carry_in.lt))
            else $error("R7: conflicting flags into slice");
    end
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output rel_t             top_rel,
    output logic             top_eq
);
    localparam int LINKS = WIDTH + 1;

    rel_t             link [LINKS];
    logic [WIDTH-1:0] eq_vec;

    assign link[0] = REL_NONE;

    for (genvar g = 0; g < WIDTH; g++) begin : g_slice
        cmp_slice u_slice (
            .x_bit    (a_in[g]),
            .y_bit    (b_in[g]),
            .carry_in (link[g]),
            .carry_out(link[g+1]),
            .eq_out   (eq_vec[g])
        );

        // Slice equal output tracks the match of the low-order prefix
        always_comb begin
            assert_prefix_eq_R3: assert (eq_vec[g] == (a_in[g:0] == b_in[g:0]))
                else $error("R3: prefix equality wrong at slice %0d", g);
        end
    end

    assign top_rel = link[WIDTH];
    assign top_eq  = eq_vec[WIDTH-1];
endmodule

// File: rtl/ripple_mag_cmp.sv
module ripple_mag_cmp
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    output logic             a_gt_b,
    output logic             a_eq_b,
    output logic             a_lt_b
);
    rel_t final_rel;
    logic final_eq;

    cmp_chain #(.WIDTH(WIDTH)) u_chain (
        .a_in   (a_val),
        .b_in   (b_val),
        .top_rel(final_rel),
        .top_eq (final_eq)
    );

    assign a_gt_b = final_rel.gt;
    assign a_lt_b = final_rel.lt;
    assign a_eq_b = final_eq;

    always_comb begin
        assert_one_result_R4: assert ($onehot({final_rel.gt, final_eq, final_rel.lt}))
            else $error("R4: result not one-hot");
        assert_greater_R1: assert (final_rel.gt == (a_val > b_val))
            else $error("R1: greater flag wrong");
        assert_less_R2: assert (final_rel.lt == (a_val < b_val))
            else $error("R2: less flag wrong");
    end
endmodule

// File: tb/ripple_mag_cmp_tb.sv
module ripple_mag_cmp_tb;
    localparam int NW = 4;
    localparam int WW = 12;
    localparam int NV = 10;

    // Code: 3'b100 greater, 3'b010 equal, 3'b001 less
    localparam logic [WW-1:0] TA [NV] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'hFFE,
                                         12'h001, 12'hA5A, 12'h5A5, 12'h800, 12'h123};
    localparam logic [WW-1:0] TB [NV] = '{12'h000, 12'hFFF, 12'h7FF, 12'h800, 12'hFFF,
                                         12'h000, 12'hA5A, 12'hA5A, 12'h801, 12'h122};
    localparam logic [2:0]    TE [NV] = '{3'b010, 3'b010, 3'b100, 3'b001, 3'b001,
                                         3'b100, 3'b010, 3'b001, 3'b001, 3'b100};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [NW-1:0] na, nb;
    logic [WW-1:0] wa, wb;
    logic ngt, neq, nlt, wgt, weq, wlt;
    int n_chk = 0;
    int n_fail = 0;

    ripple_mag_cmp #(.WIDTH(NW)) u_dut (
        .a_val(na), .b_val(nb), .a_gt_b(ngt), .a_eq_b(neq), .a_lt_b(nlt));
    ripple_mag_cmp #(.WIDTH(WW)) u_dut_wide (
        .a_val(wa), .b_val(wb), .a_gt_b(wgt), .a_eq_b(weq), .a_lt_b(wlt));

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    function automatic logic [2:0] ref_code(input logic [WW-1:0] x, input logic [WW-1:0] y);
        if (x > y) return 3'b100;
        if (x < y) return 3'b001;
        return 3'b010;
    endfunction

    task automatic drive_n(input logic [NW-1:0] x, input logic [NW-1:0] y);
        @(posedge clk);
        na = x; nb = y;
        @(negedge clk);
    endtask

    task automatic drive_w(input logic [WW-1:0] x, input logic [WW-1:0] y);
        @(posedge clk);
        wa = x; wb = y;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [WW-1:0] lfsr;
        na = '0; nb = '0; wa = '0; wb = '0;
        @(negedge clk);
        // Initial all-zero state: equal (R3, R8)
        check("R3 zero narrow", {ngt, neq, nlt}, 3'b010);
        check("R8 zero wide", {wgt, weq, wlt}, 3'b010);

        // Vector table on the wide instance (R1 R2 R3 R5 R6 R8)
        for (int k = 0; k < NV; k++) begin
            drive_w(TA[k], TB[k]);
            check("R8 table", {wgt, weq, wlt}, TE[k]);
        end

        // Exhaustive narrow sweep (R1 R2 R3 R4)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive_n(NW'(i), NW'(j));
                check("R1/R2/R3 sweep", {ngt, neq, nlt}, ref_code(WW'(i), WW'(j)));
                check("R4 onehot", {2'b00, ($countones({ngt, neq, nlt}) == 1)}, 3'b001);
            end
        end

        // Directed corners
        drive_n(4'b1000, 4'b0111); check("R5 msb wins gt", {ngt, neq, nlt}, 3'b100);
        drive_n(4'b0111, 4'b1000); check("R5 msb wins lt", {ngt, neq, nlt}, 3'b001);
        drive_n(4'b0001, 4'b0000); check("R6 fall through gt", {ngt, neq, nlt}, 3'b100);
        drive_n(4'b1110, 4'b1111); check("R6 fall through lt", {ngt, neq, nlt}, 3'b001);
        drive_n(4'b1111, 4'b1111); check("R7 all ones eq", {ngt, neq, nlt}, 3'b010);

        // Pseudo-random wide vectors (R8)
        lfsr = 12'hACE;
        for (int r = 0; r < 300; r++) begin
            logic [WW-1:0] xa;
            lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
            xa = lfsr;
            lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
            if (r % 7 == 0) drive_w(xa, xa);
            else drive_w(xa, lfsr ^ (xa & 12'hF00));
            check("R8 random", {wgt, weq, wlt}, ref_code(wa, wb));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule